// File: doc/BRIEF.md
# Programmable Down-Counter Timer Core

This block is a single countdown timer with a small word-indexed register port. Software sets a reload value, picks one of three counting modes (free-running, periodic or one-shot) and a counter width of 16 or 32 bits, and chooses a prescaler ratio. The counter then steps down once for every prescaled pulse of a clock-enable input. A step taken while the count is zero is an expiry. An expiry sets a sticky raw interrupt flag and then reloads, wraps or stops the counter, depending on the mode.

Two reload registers share one storage word. The immediate-load register also forces the count to the new value. The background-load register changes only the value used at the next periodic reload. A level-sensitive interrupt output is the raw flag gated by an enable bit, and a write to the clear register drops the flag.

The register port has a valid strobe, a write flag, a word index, write data and read data. Read data is combinational and is valid in the same cycle as the strobe.

Top module: `tmr_down_core`

## Requirements
- R1: The control word holds run (bit 7), periodic (bit 6), interrupt enable (bit 5), prescale select (bits 3:2), 32-bit width (bit 1) and one-shot (bit 0). Bit 4 and bits above 7 read as zero. After reset the control word reads 0x20.
- R2: Prescale select 00 and 11 step on every enabled tick. Select 01 steps on every 2^DIV_A_LOG2-th tick and select 10 on every 2^DIV_B_LOG2-th tick. The tick count restarts while run is clear.
- R3: Word index 0 is immediate load, 1 is the current value, 2 is control, 3 is interrupt clear, 4 is raw status, 5 is masked status and 6 is background load. Writes to index 1 are ignored. Reads of index 7 return zero.
- R4: A write to index 0 sets both the reload value and the count in the next cycle. A write to index 6 sets only the reload value and leaves the count unchanged.
- R5: Reads of index 0 and index 6 both return the stored reload value.
- R6: A step taken at count zero sets the raw flag (read at index 4, bit 0). In periodic mode the count then reloads from the reload value, so the interval between expiries is reload+1 steps.
- R7: In free-running mode (periodic and one-shot both clear), an expiry wraps the count to 0xFFFFFFFF in 32-bit mode and to 0xFFFF in 16-bit mode.
- R8: In one-shot mode an expiry leaves the count at zero and clears the run bit, so no further steps occur.
- R9: In 16-bit mode the count loads and reloads from the low 16 bits of the reload value, and bits 31:16 of the value read are zero.
- R10: The interrupt output is high exactly when the raw flag and interrupt enable are both set.
- R11: Masked status reads zero while interrupt enable is clear and reads the raw flag otherwise.
- R12: A write of any data to index 3 clears the raw flag. If an expiry occurs in the same cycle, the flag stays set.
- R13: The count changes only on a step or a load, and steps happen only on cycles with the tick input high while run is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counting clock-enable pulse |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, zero when no read is in progress |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the core with DIV_A_LOG2=2 and DIV_B_LOG2=3, so the two prescaled ratios become 4 and 8. With these values it is practical to sweep every prescale select against several reload values, including zero, and to count ticks up to each expiry. Expected tick counts come from the product (reload+1)·ratio. The 16-bit paths use reload values with non-zero upper halves, which makes the truncation visible at the value register.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   // control word bit positions
   localparam int CB_ONESHOT  = 0;
   localparam int CB_WIDE     = 1;
   localparam int CB_PRE_LO   = 2;
   localparam int CB_PRE_HI   = 3;
   localparam int CB_IE       = 5;
   localparam int CB_PERIODIC = 6;
   localparam int CB_RUN      = 7;
   localparam int CTL_W       = 8;

   localparam logic [CTL_W-1:0] CTL_KEEP     = 8'hEF;
   localparam logic [CTL_W-1:0] CTL_AT_RESET = 8'h20;

   typedef enum logic [2:0] {
      RI_LOAD   = 3'd0,
      RI_VALUE  = 3'd1,
      RI_CTRL   = 3'd2,
      RI_ICLR   = 3'd3,
      RI_RAW    = 3'd4,
      RI_MASKED = 3'd5,
      RI_BGLOAD = 3'd6
   } reg_idx_e;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
   parameter int DIV_A_LOG2 = 4,
   parameter int DIV_B_LOG2 = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       tick_en,
   input  logic [1:0] sel,
   output logic       step
);
   localparam int PW = DIV_B_LOG2;

   generate
      if (DIV_A_LOG2 < 1 || DIV_A_LOG2 >= DIV_B_LOG2 || DIV_B_LOG2 > 16) begin : g_bad_div
         $error("tmr_prescale: need 1 <= DIV_A_LOG2 < DIV_B_LOG2 <= 16");
      end
   endgenerate

   logic [PW-1:0] pcnt_q;
   logic          lo_full, hi_full, live;

   always_ff @(posedge clk) begin
      if (!rst_n)       pcnt_q <= '0;
      else if (!run)    pcnt_q <= '0;
      else if (tick_en) pcnt_q <= pcnt_q + 1'b1;
   end

   assign lo_full = &pcnt_q[DIV_A_LOG2-1:0];
   assign hi_full = &pcnt_q;
   assign live    = run & tick_en;

   always_comb begin
      unique case (sel)
         2'b01:   step = live & lo_full;
         2'b10:   step = live & hi_full;
         default: step = live;
      endcase
   end
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count #(
   parameter int CNT_W  = 32,
   parameter int HALF_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load_we,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             wide,
   input  logic             periodic,
   input  logic             oneshot,
   output logic [CNT_W-1:0] value,
   output logic             expire
);
   localparam logic [CNT_W-1:0] FULL_MAX = '1;
   localparam logic [CNT_W-1:0] HALF_MAX = CNT_W'({HALF_W{1'b1}});

   generate
      if (HALF_W < 1 || HALF_W >= CNT_W) begin : g_bad_width
         $error("tmr_count: HALF_W must lie in 1..CNT_W-1");
      end
   endgenerate

   logic [CNT_W-1:0] count_q, count_d, mask;

   assign mask   = wide ? FULL_MAX : HALF_MAX;
   assign value  = count_q & mask;
   assign expire = step & (value == '0);

   always_comb begin
      count_d = count_q;
      if (load_we)
         count_d = load_val & mask;
      else if (expire) begin
         if (oneshot)       count_d = '0;
         else if (periodic) count_d = reload_val & mask;
         else               count_d = mask;
      end else if (step)
         count_d = (value - 1'b1) & mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_d;
   end
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   input  logic [CNT_W-1:0]  value,
   input  logic              expire,
   output logic [CTL_W-1:0]  ctrl_q,
   output logic [CNT_W-1:0]  reload_q,
   output logic              raw_q,
   output logic              load_we,
   output logic [CNT_W-1:0]  bus_rdata
);
   function automatic logic at(input logic [ADDR_W-1:0] a, input reg_idx_e idx);
      return a == ADDR_W'(idx);
   endfunction

   logic wr, rd;
   assign wr      = bus_valid & bus_write;
   assign rd      = bus_valid & ~bus_write;
   assign load_we = wr & at(bus_addr, RI_LOAD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= CTL_AT_RESET;
         reload_q <= '0;
         raw_q    <= 1'b0;
      end else begin
         if (wr & at(bus_addr, RI_CTRL))
            ctrl_q <= bus_wdata[CTL_W-1:0] & CTL_KEEP;
         else if (expire & ctrl_q[CB_ONESHOT])
            ctrl_q[CB_RUN] <= 1'b0;

         if (wr & (at(bus_addr, RI_LOAD) | at(bus_addr, RI_BGLOAD)))
            reload_q <= bus_wdata;

         if (expire)
            raw_q <= 1'b1;
         else if (wr & at(bus_addr, RI_ICLR))
            raw_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         if (at(bus_addr, RI_LOAD) | at(bus_addr, RI_BGLOAD)) bus_rdata = reload_q;
         else if (at(bus_addr, RI_VALUE))  bus_rdata = value;
         else if (at(bus_addr, RI_CTRL))   bus_rdata = CNT_W'(ctrl_q);
         else if (at(bus_addr, RI_RAW))    bus_rdata = CNT_W'(raw_q);
         else if (at(bus_addr, RI_MASKED)) bus_rdata = CNT_W'(raw_q & ctrl_q[CB_IE]);
      end
   end
endmodule

// File: rtl/tmr_down_core.sv
`timescale 1ns/1ps
module tmr_down_core
   import tmr_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int HALF_W     = 16,
   parameter int DIV_A_LOG2 = 4,
   parameter int DIV_B_LOG2 = 8,
   parameter int ADDR_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq
);
   generate
      if (ADDR_W < 3)   begin : g_bad_addr  $error("tmr_down_core: ADDR_W must be at least 3"); end
      if (CNT_W < CTL_W) begin : g_bad_cnt  $error("tmr_down_core: CNT_W must hold the control word"); end
   endgenerate

   logic [CTL_W-1:0] ctrl_q;
   logic [CNT_W-1:0] reload_q, value;
   logic             raw_q, load_we, step, expire;

   tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .value(value), .expire(expire),
      .ctrl_q(ctrl_q), .reload_q(reload_q), .raw_q(raw_q), .load_we(load_we),
      .bus_rdata(bus_rdata)
   );

   tmr_prescale #(.DIV_A_LOG2(DIV_A_LOG2), .DIV_B_LOG2(DIV_B_LOG2)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q[CB_RUN]), .tick_en(tick_en),
      .sel(ctrl_q[CB_PRE_HI:CB_PRE_LO]), .step(step)
   );

   tmr_count #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .load_we(load_we),
      .load_val(bus_wdata), .reload_val(reload_q),
      .wide(ctrl_q[CB_WIDE]), .periodic(ctrl_q[CB_PERIODIC]), .oneshot(ctrl_q[CB_ONESHOT]),
      .value(value), .expire(expire)
   );

   assign irq = raw_q & ctrl_q[CB_IE];
endmodule

// File: rtl/tmr_down_chk.sv
`timescale 1ns/1ps
module tmr_down_chk
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int HALF_W = 16,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [CNT_W-1:0]  bus_wdata,
   input logic [CNT_W-1:0]  bus_rdata,
   input logic              irq,
   input logic [CTL_W-1:0]  ctrl_q,
   input logic [CNT_W-1:0]  value,
   input logic              raw_q,
   input logic              step,
   input logic              expire
);
   localparam logic [CNT_W-1:0] HMASK = CNT_W'({HALF_W{1'b1}});

   logic wr, rd;
   assign wr = bus_valid & bus_write;
   assign rd = bus_valid & ~bus_write;

   AST_STEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (ctrl_q[CB_RUN] && tick_en));  // R13
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[CB_RUN] && !wr) |=> $stable(value));  // R13
   AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == ADDR_W'(RI_LOAD)) |=>
         value == ($past(bus_wdata) & (ctrl_q[CB_WIDE] ? {CNT_W{1'b1}} : HMASK)));  // R4
   AST_BG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == ADDR_W'(RI_BGLOAD) && !step) |=> $stable(value));  // R4
   AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> raw_q);  // R6
   AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctrl_q[CB_ONESHOT] && !wr) |=> (!ctrl_q[CB_RUN] && value == '0));  // R8
   AST_HALF_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == ADDR_W'(RI_VALUE) && !ctrl_q[CB_WIDE]) |-> bus_rdata[CNT_W-1:HALF_W] == '0);  // R9
   AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ctrl_q[CB_IE]);  // R10
   AST_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == ADDR_W'(RI_MASKED) && !ctrl_q[CB_IE]) |-> bus_rdata == '0);  // R11
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == ADDR_W'(RI_ICLR) && !expire) |=> !irq);  // R12
endmodule

bind tmr_down_core tmr_down_chk #(.CNT_W(CNT_W), .HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
   .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
   .ctrl_q(ctrl_q), .value(value), .raw_q(raw_q), .step(step), .expire(expire)
);

// File: tb/tmr_down_core_test.sv
`timescale 1ns/1ps
module tmr_down_core_test;
   localparam int CW = 32, HW = 16, DA = 2, DB = 3, AW = 3;

   logic          clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
   logic          bus_valid = 1'b0, bus_write = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [CW-1:0] bus_wdata = '0;
   logic [CW-1:0] bus_rdata;
   logic          irq;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   tmr_down_core #(.CNT_W(CW), .HALF_W(HW), .DIV_A_LOG2(DA), .DIV_B_LOG2(DB), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      @(negedge clk);
      tick_en = 1'b0; bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(idx); bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(idx);
      #1 d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic expect_rd(input string req, input int idx, input logic [31:0] exp);
      logic [31:0] d;
      rd(idx, d);
      check(req, d, exp);
   endtask

   task automatic run_until_irq(input int every, output int ticks);
      ticks = 0;
      for (int k = 0; k < 4000; k++) begin
         if (irq) break;
         tick_en = ((k % every) == 0);
         if (tick_en) ticks++;
         @(negedge clk);
      end
      tick_en = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_en = 1'b1;
         @(negedge clk);
      end
      tick_en = 1'b0;
   endtask

   task automatic quiesce();
      wr(2, 32'h20);
      wr(3, 32'h0);
   endtask

   initial begin
      #(5.0 * 150000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      expect_rd("R1 reset ctrl", 2, 32'h20);
      expect_rd("R13 reset value", 1, 32'h0);
      expect_rd("R5 reset load", 0, 32'h0);
      expect_rd("R6 reset raw", 4, 32'h0);
      check("R10 reset irq", irq, 1'b0);
      expect_rd("R3 unmapped", 7, 32'h0);

      // control mask
      wr(2, 32'hFFFF_FFFF);
      expect_rd("R1 ctrl mask", 2, 32'hEF);
      quiesce();

      // immediate vs background load, value write ignored
      wr(0, 7);
      expect_rd("R4 load sets count", 1, 7);
      wr(6, 3);
      expect_rd("R4 bg keeps count", 1, 7);
      expect_rd("R5 load reads reload", 0, 3);
      expect_rd("R5 bg reads reload", 6, 3);
      wr(1, 32'h55);
      expect_rd("R3 value write ignored", 1, 7);

      wr(2, 32'hE2);
      run_until_irq(1, t);
      check("R6 first period", t, 8);
      expect_rd("R6 periodic reload", 1, 3);
      wr(3, 32'h0);
      expect_rd("R12 clear raw", 4, 0);
      run_until_irq(1, t);
      check("R6 bg period", t, 4);

      // prescaler sweep
      for (int sel = 0; sel < 4; sel++) begin
         for (int n = 0; n < 4; n++) begin
            int div;
            div = (sel == 1) ? (1 << DA) : (sel == 2) ? (1 << DB) : 1;
            quiesce();
            wr(0, n);
            wr(2, 32'hE2 | (sel << 2));
            run_until_irq(1, t);
            check($sformatf("R2 sel%0d n%0d", sel, n), t, (n + 1) * div);
         end
      end

      // sparse ticks and disabled hold
      quiesce();
      wr(0, 2);
      wr(2, 32'hE2);
      run_until_irq(3, t);
      check("R13 sparse ticks", t, 3);
      quiesce();
      wr(0, 5);
      run_ticks(10);
      expect_rd("R13 disabled hold", 1, 5);

      // free-running wrap, 32 and 16 bit
      wr(2, 32'hA2);
      run_until_irq(1, t);
      check("R6 free expiry", t, 6);
      expect_rd("R7 wrap 32", 1, 32'hFFFF_FFFF);
      quiesce();
      wr(0, 32'h1234_0002);
      expect_rd("R9 half load", 1, 32'h2);
      expect_rd("R5 full reload kept", 0, 32'h1234_0002);
      wr(2, 32'hA0);
      run_until_irq(1, t);
      check("R9 half expiry", t, 3);
      expect_rd("R7 wrap 16", 1, 32'hFFFF);
      run_ticks(1);
      expect_rd("R9 half decrement", 1, 32'hFFFE);
      quiesce();
      wr(0, 32'h0003_0001);
      wr(2, 32'hE0);
      run_until_irq(1, t);
      check("R9 half periodic", t, 2);
      expect_rd("R9 half reload", 1, 32'h1);

      // one-shot
      quiesce();
      wr(0, 1);
      wr(2, 32'hA3);
      run_until_irq(1, t);
      check("R8 oneshot expiry", t, 2);
      expect_rd("R8 holds zero", 1, 0);
      expect_rd("R8 run cleared", 2, 32'h23);
      run_ticks(5);
      expect_rd("R8 stays zero", 1, 0);

      // masking
      wr(2, 32'h03);
      check("R10 irq masked", irq, 1'b0);
      expect_rd("R11 masked zero", 5, 0);
      expect_rd("R11 raw kept", 4, 1);
      wr(2, 32'h23);
      check("R10 irq unmasked", irq, 1'b1);
      expect_rd("R11 masked raw", 5, 1);
      wr(3, 32'h1234);
      check("R12 irq cleared", irq, 1'b0);
      expect_rd("R12 raw cleared", 4, 0);

      // clear collides with expiry
      quiesce();
      wr(0, 0);
      wr(2, 32'hE2);
      @(negedge clk);
      tick_en = 1'b1; bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(3); bus_wdata = 0;
      @(negedge clk);
      tick_en = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
      expect_rd("R12 expiry wins", 4, 1);

      // load while running
      quiesce();
      wr(0, 100);
      wr(2, 32'hA2);
      run_ticks(10);
      expect_rd("R13 running count", 1, 90);
      wr(0, 4);
      expect_rd("R4 load while running", 1, 4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule